// File: doc/BRIEF.md
# Bit-Sliced Four-Column Word Store

This block is a byte-wide random-access store assembled from single-bit storage slices rather than one wide RAM. The slices are arranged as four columns of eight. Within a column, slice i always holds data bit i of every word. The low part of the address goes unchanged to every slice in every column. The two highest address bits go to a 2-to-4 decoder, which raises the enable of exactly one column whenever a write or a read is requested.

With the full depth parameter `LOW_AW = 18`, each slice holds 256K bits, the address is 20 bits and the store holds 1M bytes. For simulation the default `LOW_AW = 6` shrinks every slice to 64 bits. The column decode still uses the top two address bits. Writes take effect at the clock edge. A read strobe returns the addressed byte on `rd_data` one clock later, with `rd_valid` high for that cycle. `rd_data` then holds its value until the next read.

The read sequencer has two states. `ST_IDLE` means no read result is being presented. `ST_RESP` means `rd_data` carries the result of the strobe taken at the previous edge. The transitions are: `ST_IDLE` to `ST_RESP` when a strobe is taken; `ST_RESP` to `ST_RESP` on a back-to-back strobe; `ST_RESP` to `ST_IDLE` when no strobe is present; and `ST_IDLE` to `ST_IDLE` otherwise.

Top module: `sliced_word_store`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rd_valid` is 0 and `rd_data` is 0 until the first read strobe is taken.
- R2: A byte written to an address is returned by a later read of that address. The read result appears on `rd_data` in the cycle after the edge that takes `rd_en`, with `rd_valid` = 1 in exactly that cycle. With no strobe, `rd_valid` is 0 in the following cycle.
- R3: The column is selected by address bits [LOW_AW+1:LOW_AW], with values 0 to 3. Addresses that share their low bits but differ in these two bits hold independent bytes, so a write to one column leaves the other three unchanged.
- R4: Addresses within one column that differ only in their low LOW_AW bits hold independent bytes.
- R5: At most one column enable is high in any cycle. Exactly one is high whenever `wr_en` or `rd_en` is high.
- R6: Data presented on `wr_data` while `wr_en` is 0 has no effect on stored contents.
- R7: When `wr_en` and `rd_en` are both high for the same address, the read returns the contents from before that write, and a later read returns the new byte.
- R8: While no read strobe is taken, `rd_data` keeps the last value read.
- R9: Read strobes on consecutive cycles each return their own byte, one cycle after their own strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the read path |
| addr | input | LOW_AW+2 | Word address; top two bits pick the column |
| wr_data | input | 8 | Byte to store |
| wr_en | input | 1 | Write the byte at the address on this edge |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Byte from the most recent read |
| rd_valid | output | 1 | High in the cycle after a read strobe |

## Verification
The bench stores the same low address in all four columns. A decoder that ignored or swapped the column bits would return another column's byte, or the last byte written. It drives write data with the enable low, which catches an enable that leaks into the slices. It also issues a read and a write in the same cycle: a store with write-first behaviour would return the new byte too early. Back-to-back reads and idle cycles after a read expose a response register that misses a strobe or lets `rd_data` drift or clear between reads.

// File: rtl/sliced_word_store_pkg.sv
package sliced_word_store_pkg;
    localparam int NUM_COLS  = 4;
    localparam int COL_SEL_W = $clog2(NUM_COLS);
    localparam int WORD_W    = 8;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rd_state_t;
endpackage

// File: rtl/bit_slice.sv
module bit_slice #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          we,
    input  logic          rd_any,
    input  logic [AW-1:0] addr,
    input  logic          din,
    output logic          dout
);
    localparam int DEPTH = 1 << AW;

    logic cells [DEPTH];
    logic q;
    logic owned;

    // storage and captured read bit
    always_ff @(posedge clk) begin
        if (ce && we) begin
            cells[addr] <= din;
        end
        if (ce && rd_any) begin
            q <= cells[addr];
        end
    end

    // this slice drives the read path only if it served the last strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owned <= 1'b0;
        end else if (rd_any) begin
            owned <= ce;
        end
    end

    assign dout = owned & q;
endmodule

// File: rtl/column_group.sv
module column_group #(
    parameter int AW     = 6,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              we,
    input  logic              rd_any,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    // bit b of the word lives in slice b
    for (genvar b = 0; b < WORD_W; b++) begin : g_slice
        bit_slice #(.AW(AW)) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .ce     (ce),
            .we     (we),
            .rd_any (rd_any),
            .addr   (addr),
            .din    (din[b]),
            .dout   (dout[b])
        );
    end
endmodule

// File: rtl/col_decode.sv
module col_decode #(
    parameter int SEL_W = 2,
    parameter int N     = 4
) (
    input  logic             access,
    input  logic [SEL_W-1:0] sel,
    output logic [N-1:0]     en
);
    for (genvar g = 0; g < N; g++) begin : g_en
        assign en[g] = access && (sel == SEL_W'(g));
    end
endmodule

// File: rtl/sliced_word_store.sv
module sliced_word_store
    import sliced_word_store_pkg::*;
#(
    parameter int LOW_AW = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LOW_AW+COL_SEL_W-1:0] addr,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic                       wr_en,
    input  logic                       rd_en,
    output logic [WORD_W-1:0]          rd_data,
    output logic                       rd_valid
);
    localparam int ADDR_W = LOW_AW + COL_SEL_W;

    logic [NUM_COLS-1:0]  col_en;
    logic [WORD_W-1:0]    col_q [NUM_COLS];
    logic [LOW_AW-1:0]    low_addr;
    logic [COL_SEL_W-1:0] col_sel;
    rd_state_t            state_q, state_d;

    assign low_addr = addr[LOW_AW-1:0];
    assign col_sel  = addr[ADDR_W-1:LOW_AW];

    col_decode #(.SEL_W(COL_SEL_W), .N(NUM_COLS)) u_dec (
        .access (wr_en | rd_en),
        .sel    (col_sel),
        .en     (col_en)
    );

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        column_group #(.AW(LOW_AW), .WORD_W(WORD_W)) u_col (
            .clk    (clk),
            .rst_n  (rst_n),
            .ce     (col_en[c]),
            .we     (wr_en),
            .rd_any (rd_en),
            .addr   (low_addr),
            .din    (wr_data),
            .dout   (col_q[c])
        );
    end

    // only the column that served the last read drives nonzero bits
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_COLS; c++) begin
            rd_data = rd_data | col_q[c];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        rd_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_en) state_d = ST_RESP;
            end
            ST_RESP: begin
                rd_valid = 1'b1;
                state_d  = rd_en ? ST_RESP : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/sliced_word_store_chk.sv
module sliced_word_store_chk #(
    parameter int NCOL   = 4,
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [NCOL-1:0]   col_en,
    input logic [WORD_W-1:0] rd_data,
    input logic              rd_valid
);
    assert_sel_onehot0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_en));

    assert_sel_on_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rd_en) |-> ($countones(col_en) == 1));

    assert_resp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind sliced_word_store sliced_word_store_chk #(
    .NCOL   (sliced_word_store_pkg::NUM_COLS),
    .WORD_W (sliced_word_store_pkg::WORD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .col_en   (col_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
);

// File: tb/sliced_word_store_test.sv
`timescale 1ns/1ps
module sliced_word_store_test;
    localparam int LOW_AW = 6;
    localparam int AW     = LOW_AW + 2;
    localparam int NVEC   = 8;
    // each entry: {address, byte}
    localparam logic [AW+7:0] VEC [NVEC] = '{
        {8'h05, 8'h11}, {8'h45, 8'h22}, {8'h85, 8'h44}, {8'hC5, 8'h88},
        {8'h06, 8'hA5}, {8'h00, 8'h00}, {8'h3F, 8'hFF}, {8'hFF, 8'h5A}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wr_data = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic          rd_valid;
    int            checks = 0;
    int            failures = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    sliced_word_store #(.LOW_AW(LOW_AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, {rd_valid, rd_data}, {1'b1, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", {rd_valid, rd_data}, 9'h000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after release", {rd_valid, rd_data}, 9'h000);

        // table: fill, then read back (R2, R3 columns, R4 low bits)
        for (int i = 0; i < NVEC; i++) do_write(VEC[i][AW+7:8], VEC[i][7:0]);
        for (int i = 0; i < NVEC; i++) do_read("R2/R3/R4 table", VEC[i][AW+7:8], VEC[i][7:0]);

        // R3: rewrite column 2 only, others keep their bytes
        do_write(8'h85, 8'h3C);
        do_read("R3 col0 untouched", 8'h05, 8'h11);
        do_read("R3 col1 untouched", 8'h45, 8'h22);
        do_read("R3 col2 updated", 8'h85, 8'h3C);
        do_read("R3 col3 untouched", 8'hC5, 8'h88);

        // R6: data without enable
        @(negedge clk);
        addr = 8'h05; wr_data = 8'h77;
        repeat (2) @(negedge clk);
        do_read("R6 no write without enable", 8'h05, 8'h11);

        // R7: simultaneous read and write
        @(negedge clk);
        addr = 8'h45; wr_data = 8'h99; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R7 old data returned", {rd_valid, rd_data}, {1'b1, 8'h22});
        do_read("R7 new data later", 8'h45, 8'h99);

        // R8: hold after read, R2 no valid without strobe
        do_read("R8 setup", 8'h3F, 8'hFF);
        @(negedge clk);
        check("R2 valid drops", {8'h00, rd_valid}, 9'h000);
        do_write(8'h06, 8'h01);
        repeat (2) @(negedge clk);
        check("R8 data held", {rd_valid, rd_data}, {1'b0, 8'hFF});

        // R9: back-to-back reads
        @(negedge clk);
        addr = 8'hC5; rd_en = 1'b1;
        @(negedge clk);
        check("R9 first of pair", {rd_valid, rd_data}, {1'b1, 8'h88});
        addr = 8'h06;
        @(negedge clk);
        rd_en = 1'b0;
        check("R9 second of pair", {rd_valid, rd_data}, {1'b1, 8'h01});

        // R1: reset mid-run clears the read path
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset", {rd_valid, rd_data}, 9'h000);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule